// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block gathers interrupt requests from peripherals into several identical register banks and raises one summary interrupt per bank toward the processor. Each bank holds up to 32 lines. A request line is latched as pending when its level rises, and the pending bit stays set after the request falls until software clears it.

Software reaches every bank through a plain 32-bit register port. Reads are combinational and writes take effect on the next clock edge. Each bank has five registers:
- a pending register, cleared by writing ones to it;
- an enable register;
- a read-only view of the pending bits that are enabled;
- a write-only register that forces pending bits, used to raise interrupts in test;
- a read-only view of the pending bits that are blocked by their enable bit.

Each bank also reports the index of its highest-numbered enabled pending line, with a valid flag. A dispatcher can use this winner without scanning the register itself.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every pending and enable bit is zero, every `irq_o` and `win_vld_o` bit is low, and every register reads zero.
- R2: A 0-to-1 change on `req_i[b*LINES+i]` sets pending bit i of bank b at the next clock edge. The bit stays set after the request returns low. A request held high does not set the bit again after it has been cleared.
- R3: Writing to bank offset 0x00 clears each pending bit whose data bit is one, and leaves the bits written as zero unchanged. An all-ones write clears the whole bank. Reading offset 0x00 returns the pending bits.
- R4: Offset 0x08 is the enable register. It is readable and writable as a full word.
- R5: Offset 0x10 reads pending AND enable. Writes to it change nothing.
- R6: Writing ones to offset 0x18 sets the corresponding pending bits. This offset reads as zero.
- R7: Offset 0x20 reads pending AND NOT enable. Writes to it change nothing.
- R8: `irq_o[b]` is high exactly when the offset 0x10 value of bank b is non-zero.
- R9: `win_idx_o[b*5 +: 5]` gives the highest-numbered set bit of the offset 0x10 value of bank b, and `win_vld_o[b]` is high when that value is non-zero. When the value is zero, the index is 0.
- R10: Bank b starts at byte address b*0x28, for b from 0 to 4. Any address outside the five offsets of a bank reads zero and its writes are ignored. This includes every address from 0xC8 upward.
- R11: When a rising request or a write to offset 0x18 meets a write to offset 0x00 for the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_BANKS*LINES | Request lines. Bit b*LINES+i is line i of bank b |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | NUM_BANKS | Summary interrupt, one per bank |
| win_idx_o | output | NUM_BANKS*IDX_W | Highest enabled pending line of each bank |
| win_vld_o | output | NUM_BANKS | Winner valid, one per bank |

## Verification
The bench uses the default parameters: five banks of 32 lines at a 0x28 stride. This lets it sweep every line of every bank through capture, the winner encoder and clearing, and check each bank against an arithmetic model. Using the full default width reaches the edge indices 0 and 31, the last bank and the first unmapped address 0xC8. These are the places where bank decode and the priority scan are most likely to slip. Directed cases add a request held at a steady level and a collision between a clear and a capture in the same cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   localparam int unsigned BUS_W       = 32;
   localparam int unsigned OFS_PEND    = 32'h00;
   localparam int unsigned OFS_ENABLE  = 32'h08;
   localparam int unsigned OFS_OUT     = 32'h10;
   localparam int unsigned OFS_FORCE   = 32'h18;
   localparam int unsigned OFS_BLOCKED = 32'h20;
   localparam int unsigned OFS_SPAN    = 32'h24;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_PEND,
      RK_ENABLE,
      RK_OUT,
      RK_FORCE,
      RK_BLOCKED
   } reg_kind_e;

   function automatic reg_kind_e kind_of(input int unsigned ofs);
      case (ofs)
         OFS_PEND:    return RK_PEND;
         OFS_ENABLE:  return RK_ENABLE;
         OFS_OUT:     return RK_OUT;
         OFS_FORCE:   return RK_FORCE;
         OFS_BLOCKED: return RK_BLOCKED;
         default:     return RK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/irq_ctrl_msb_enc.sv
module irq_ctrl_msb_enc #(
   parameter int unsigned W     = 32,
   parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             vld
);

   always_comb begin
      idx = '0;
      vld = 1'b0;
      for (int i = 0; i < int'(W); i++) begin
         if (vec[i]) begin
            idx = IDX_W'(i);
            vld = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irq_ctrl_decode.sv
module irq_ctrl_decode
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 5,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STRIDE    = 40
) (
   input  logic [ADDR_W-1:0]    bus_addr,
   output logic [NUM_BANKS-1:0] bank_sel,
   output reg_kind_e            kind
);

   int unsigned a;

   always_comb begin
      a        = 32'(bus_addr);
      bank_sel = '0;
      kind     = RK_NONE;
      for (int unsigned b = 0; b < NUM_BANKS; b++) begin
         if (a >= b * STRIDE && a < (b + 1) * STRIDE) begin
            kind = kind_of(a - b * STRIDE);
            if (kind != RK_NONE) bank_sel[b] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank #(
   parameter int unsigned LINES = 32,
   parameter int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req,
   input  logic [LINES-1:0] clr_mask,
   input  logic [LINES-1:0] set_mask,
   input  logic             en_we,
   input  logic [LINES-1:0] en_wdata,
   output logic [LINES-1:0] pend,
   output logic [LINES-1:0] en,
   output logic [LINES-1:0] outv,
   output logic             irq,
   output logic [IDX_W-1:0] idx,
   output logic             vld
);

   logic [LINES-1:0] req_q;
   logic [LINES-1:0] rise;

   assign rise = req & ~req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         pend  <= '0;
         en    <= '0;
      end else begin
         req_q <= req;
         // capture and force win over clear of the same bit
         pend  <= (pend & ~clr_mask) | rise | set_mask;
         if (en_we) en <= en_wdata;
      end
   end

   assign outv = pend & en;

   irq_ctrl_msb_enc #(.W(LINES), .IDX_W(IDX_W)) u_enc (
      .vec (outv),
      .idx (idx),
      .vld (vld)
   );

   assign irq = |outv;

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 5,
   parameter int unsigned LINES     = 32,
   parameter int unsigned STRIDE    = 40,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned IDX_W     = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_BANKS*LINES-1:0] req_i,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_wr,
   input  logic [BUS_W-1:0]           bus_wdata,
   output logic [BUS_W-1:0]           bus_rdata,
   output logic [NUM_BANKS-1:0]       irq_o,
   output logic [NUM_BANKS*IDX_W-1:0] win_idx_o,
   output logic [NUM_BANKS-1:0]       win_vld_o
);

   localparam int unsigned TOTAL = NUM_BANKS * LINES;
   localparam int unsigned SPACE = NUM_BANKS * STRIDE;

   generate
      if (LINES < 1 || LINES > BUS_W) begin : g_bad_lines
         $error("LINES must lie in 1..32");
      end
      if (STRIDE < OFS_SPAN) begin : g_bad_stride
         $error("STRIDE too small for the bank layout");
      end
      if (NUM_BANKS < 1 || (64'd1 << ADDR_W) < 64'(SPACE)) begin : g_bad_addr
         $error("ADDR_W cannot reach every bank");
      end
   endgenerate

   logic [NUM_BANKS-1:0] bank_sel;
   reg_kind_e            kind;

   irq_ctrl_decode #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W),
      .STRIDE    (STRIDE)
   ) u_dec (
      .bus_addr (bus_addr),
      .bank_sel (bank_sel),
      .kind     (kind)
   );

   logic [TOTAL-1:0] pend_all;
   logic [TOTAL-1:0] en_all;
   logic [TOTAL-1:0] out_all;
   logic [TOTAL-1:0] clr_mask_all;
   logic [TOTAL-1:0] set_mask_all;

   genvar gb;
   generate
      for (gb = 0; gb < int'(NUM_BANKS); gb++) begin : g_bank
         logic clr_we, set_we, en_we;

         assign clr_we = bus_wr & bank_sel[gb] & (kind == RK_PEND);
         assign set_we = bus_wr & bank_sel[gb] & (kind == RK_FORCE);
         assign en_we  = bus_wr & bank_sel[gb] & (kind == RK_ENABLE);

         assign clr_mask_all[gb*LINES +: LINES] = {LINES{clr_we}} & bus_wdata[LINES-1:0];
         assign set_mask_all[gb*LINES +: LINES] = {LINES{set_we}} & bus_wdata[LINES-1:0];

         irq_ctrl_bank #(.LINES(LINES), .IDX_W(IDX_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req_i[gb*LINES +: LINES]),
            .clr_mask (clr_mask_all[gb*LINES +: LINES]),
            .set_mask (set_mask_all[gb*LINES +: LINES]),
            .en_we    (en_we),
            .en_wdata (bus_wdata[LINES-1:0]),
            .pend     (pend_all[gb*LINES +: LINES]),
            .en       (en_all[gb*LINES +: LINES]),
            .outv     (out_all[gb*LINES +: LINES]),
            .irq      (irq_o[gb]),
            .idx      (win_idx_o[gb*IDX_W +: IDX_W]),
            .vld      (win_vld_o[gb])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
         if (bank_sel[b]) begin
            case (kind)
               RK_PEND:    bus_rdata[LINES-1:0] = pend_all[b*LINES +: LINES];
               RK_ENABLE:  bus_rdata[LINES-1:0] = en_all[b*LINES +: LINES];
               RK_OUT:     bus_rdata[LINES-1:0] = out_all[b*LINES +: LINES];
               RK_BLOCKED: bus_rdata[LINES-1:0] = pend_all[b*LINES +: LINES]
                                                & ~en_all[b*LINES +: LINES];
               default:    bus_rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
   parameter int unsigned NUM_BANKS = 5,
   parameter int unsigned LINES     = 32,
   parameter int unsigned IDX_W     = 5
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_BANKS*LINES-1:0] req_i,
   input logic [NUM_BANKS*LINES-1:0] pend_all,
   input logic [NUM_BANKS*LINES-1:0] en_all,
   input logic [NUM_BANKS*LINES-1:0] out_all,
   input logic [NUM_BANKS*LINES-1:0] clr_mask_all,
   input logic [NUM_BANKS*LINES-1:0] set_mask_all,
   input logic [NUM_BANKS-1:0]       bank_sel,
   input logic [NUM_BANKS-1:0]       irq_o,
   input logic [NUM_BANKS*IDX_W-1:0] win_idx_o,
   input logic [NUM_BANKS-1:0]       win_vld_o
);

   logic [NUM_BANKS*LINES-1:0] req_prev;
   logic [NUM_BANKS*LINES-1:0] arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_prev <= '0;
      else        req_prev <= req_i;
   end

   assign arm = (req_i & ~req_prev) | set_mask_all;

   AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(arm) & ~pend_all) == '0)); // R11

   AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_all) & ~$past(clr_mask_all)) & ~pend_all) == '0)); // R2

   AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_all & ~en_all) == '0); // R5

   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_sel)); // R10

   genvar gb;
   generate
      for (gb = 0; gb < int'(NUM_BANKS); gb++) begin : g_b
         logic [LINES-1:0] ov;
         logic [IDX_W-1:0] ix;
         assign ov = out_all[gb*LINES +: LINES];
         assign ix = win_idx_o[gb*IDX_W +: IDX_W];

         AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[gb] == (ov != '0)); // R8

         AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !win_vld_o[gb] |-> (ix == '0 && ov == '0)); // R9

         AST_IDX_TOP: assert property (@(posedge clk) disable iff (!rst_n)
            win_vld_o[gb] |-> ((ov >> ix) == LINES'(1))); // R9
      end
   endgenerate

endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(
   .NUM_BANKS (NUM_BANKS),
   .LINES     (LINES),
   .IDX_W     (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .pend_all     (pend_all),
   .en_all       (en_all),
   .out_all      (out_all),
   .clr_mask_all (clr_mask_all),
   .set_mask_all (set_mask_all),
   .bank_sel     (bank_sel),
   .irq_o        (irq_o),
   .win_idx_o    (win_idx_o),
   .win_vld_o    (win_vld_o)
);

// File: tb/banked_irq_ctrl_tb.sv
module banked_irq_ctrl_tb;

   localparam int NB = 5;
   localparam int NL = 32;
   localparam int ST = 40;
   localparam int IW = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NB*NL-1:0] req_i = '0;
   logic [7:0]       bus_addr = '0;
   logic             bus_wr = 1'b0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic [NB-1:0]    irq_o;
   logic [NB*IW-1:0] win_idx_o;
   logic [NB-1:0]    win_vld_o;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   banked_irq_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .win_idx_o (win_idx_o),
      .win_vld_o (win_vld_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = 8'(addr);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [31:0] d);
      bus_addr = 8'(addr);
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] msb_of(input logic [31:0] v);
      logic [31:0] r = 0;
      for (int i = 0; i < 32; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic pulse(input int b, input int i);
      @(negedge clk);
      req_i[b*NL+i] = 1'b1;
      @(negedge clk);
      req_i[b*NL+i] = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] d, p, e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 vld", 32'(win_vld_o), 0);
      for (int b = 0; b < NB; b++) begin
         rd(b*ST + 'h00, d); chk("R1 pend", d, 0);
         rd(b*ST + 'h08, d); chk("R1 enable", d, 0);
      end

      // sweep every line of every bank
      for (int b = 0; b < NB; b++) begin
         wr(b*ST + 'h08, 32'hFFFF_FFFF);
         rd(b*ST + 'h08, d); chk("R4 enable readback", d, 32'hFFFF_FFFF);
         for (int i = 0; i < NL; i++) begin
            pulse(b, i);
            rd(b*ST + 'h00, d); chk("R2 capture", d, 32'(1) << i);
            rd(b*ST + 'h10, d); chk("R5 out", d, 32'(1) << i);
            chk("R8 irq bank", 32'(irq_o), 32'(1) << b);
            chk("R9 idx", 32'(win_idx_o[b*IW +: IW]), i);
            chk("R9 vld", 32'(win_vld_o[b]), 1);
            pulse(b, 0);
            chk("R9 highest wins", 32'(win_idx_o[b*IW +: IW]), i);
            wr(b*ST + 'h00, 32'(1) << i);
            rd(b*ST + 'h00, d); chk("R3 single clear", d, (i == 0) ? 0 : 1);
            wr(b*ST + 'h00, 32'hFFFF_FFFF);
            rd(b*ST + 'h00, d); chk("R3 full clear", d, 0);
            chk("R9 idle idx", 32'(win_idx_o[b*IW +: IW]), 0);
         end
      end

      // force register patterns with partial enables
      for (int b = 0; b < NB; b++) begin
         e = 32'h0F0F_00FF << b;
         p = 32'hA5A5_5A5A ^ (32'h1111_0001 * (b + 1));
         wr(b*ST + 'h08, e);
         wr(b*ST + 'h18, p);
         rd(b*ST + 'h00, d); chk("R6 force sets", d, p);
         rd(b*ST + 'h18, d); chk("R6 force reads zero", d, 0);
         rd(b*ST + 'h10, d); chk("R5 out masked", d, p & e);
         rd(b*ST + 'h20, d); chk("R7 blocked view", d, p & ~e);
         chk("R8 irq", 32'(irq_o[b]), 32'((p & e) != 0));
         chk("R9 idx pattern", 32'(win_idx_o[b*IW +: IW]), msb_of(p & e));
         wr(b*ST + 'h10, 32'hFFFF_FFFF);
         wr(b*ST + 'h20, 32'hFFFF_FFFF);
         rd(b*ST + 'h00, d); chk("R7 write ignored pend", d, p);
         rd(b*ST + 'h08, d); chk("R5 write ignored enable", d, e);
         wr(b*ST + 'h00, 32'h0000_FFFF);
         rd(b*ST + 'h00, d); chk("R3 partial clear", d, p & 32'hFFFF_0000);
         wr(b*ST + 'h00, 32'hFFFF_FFFF);
         wr(b*ST + 'h08, 32'hFFFF_FFFF);
      end

      // R2 level held high is not recaptured
      @(negedge clk); req_i[1*NL+3] = 1'b1;
      @(negedge clk);
      rd(1*ST, d); chk("R2 level capture", d, 32'h8);
      wr(1*ST, 32'h8);
      repeat (2) @(negedge clk);
      rd(1*ST, d); chk("R2 held level no recapture", d, 0);
      req_i[1*NL+3] = 1'b0;

      // R11 capture meets clear in the same cycle
      @(negedge clk);
      req_i[2*NL+7] = 1'b1;
      bus_addr = 8'(2*ST); bus_wdata = 32'h80; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; req_i[2*NL+7] = 1'b0;
      rd(2*ST, d); chk("R11 capture beats clear", d, 32'h80);
      wr(2*ST, 32'hFFFF_FFFF);

      // R10 unmapped addresses
      wr(200, 32'hFFFF_FFFF);
      wr(255, 32'hFFFF_FFFF);
      wr(1*ST + 'h04, 32'hFFFF_FFFF);
      wr(3*ST + 'h24, 32'hFFFF_FFFF);
      rd(200, d); chk("R10 unmapped read", d, 0);
      rd(1*ST + 'h04, d); chk("R10 hole read", d, 0);
      for (int b = 0; b < NB; b++) begin
         rd(b*ST, d); chk("R10 no stray set", d, 0);
      end
      chk("R10 irq quiet", 32'(irq_o), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule